// File: doc/BRIEF.md
# Three-Level Drift Compensator

This block sits between the oscillator domain and the calendar of a timekeeping unit. It divides the slow clock into a one-second tick and nudges the length of selected seconds, so that a known oscillator error is cancelled at calendar boundaries. There are three correction levels: one for every hour, a second for every day and a third for every month. Each level is programmed with an 8-bit code. The code holds a direction bit and a BCD magnitude stored as the value minus one.

The calendar reports its position with three flags: the last minute of the hour, the last hour of the day, and the last day of the month. When the last-minute flag rises, the block adds up the signed amounts of every level that applies to that minute and holds the total as a pending budget. Each correction unit is one slow-clock cycle. A positive budget (time added) shortens the following seconds, by at most half a nominal second each. A negative budget (time removed) lengthens the next second by the whole amount. A global enable gates all correction.

The controller is a three-state machine:
- **IDLE**: no budget is pending. Moves to **ADVANCE** when a positive total is loaded, or to **RETARD** when a negative total is loaded.
- **ADVANCE**: consumes up to half a second per tick. Returns to **IDLE** when the budget is used up.
- **RETARD**: returns to **IDLE** after the one lengthened second.
- Dropping the enable forces **IDLE** from any state.

Top module: `drift_compensator`

## Requirements
- R1: During and after reset, `tick_o` and `trim_active_o` are low, and the first tick appears in the TICK_CYCLES-th clock cycle after reset is released.
- R2: With no correction pending, consecutive ticks are exactly TICK_CYCLES cycles apart.
- R3: In a level code, bit 7 set means add time and clear means remove time. Bits 6:4 are the BCD tens digit and bits 3:0 the BCD ones digit of the magnitude minus one. A ones digit above 9 counts as 9.
- R4: The code 0x01 gives no correction at its level.
- R5: The hourly level is applied once, on the rising edge of `last_min_i`. The second that is running at that moment keeps its nominal length, and the correction begins with the next second.
- R6: The daily level is included only if `last_hour_i` is high at the rising edge. The monthly level is included only if `last_hour_i` and `last_day_i` are both high. All included levels are summed as signed values into one budget.
- R7: A positive budget shortens each following second by min(budget, TICK_CYCLES/2) until the budget is used up. No second is ever shorter than TICK_CYCLES/2.
- R8: A negative budget lengthens the next second by its full magnitude, and is then cleared.
- R9: While `comp_en_i` is low, no budget is loaded, any pending budget is discarded, and the next second has nominal length.
- R10: `trim_active_o` is high exactly while a nonzero budget is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | slow oscillator clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| comp_en_i | input | 1 | global correction enable |
| hour_code_i | input | 8 | hourly level code |
| day_code_i | input | 8 | daily level code |
| month_code_i | input | 8 | monthly level code |
| last_min_i | input | 1 | calendar is in the last minute of the hour |
| last_hour_i | input | 1 | calendar is in the last hour of the day |
| last_day_i | input | 1 | calendar is in the last day of the month |
| tick_o | output | 1 | one-cycle pulse at the end of each second |
| trim_active_o | output | 1 | correction budget pending |

## Verification
The assertions assume the following about the inputs:
- The calendar flags change at most once per second, and not in the cycle where `tick_o` is high.
- The codes stay stable around the rising edge of `last_min_i`.
- TICK_CYCLES is at least 2.

The directed tasks keep to these assumptions. They change the flags and the enable only at the falling clock edge that follows an observed tick, and they clear the flags only after the whole budget has played out.

// File: rtl/drift_comp_pkg.sv
package drift_comp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADVANCE = 2'd1,
        ST_RETARD  = 2'd2
    } trim_state_t;

    localparam int CODE_W  = 8;
    localparam int MAG_W   = 7;
    localparam int MAG_MAX = 80;
    localparam int LEVELS  = 3;
    localparam int SUM_W   = 10;

    // Convert a two-digit BCD field (magnitude minus one) into the real magnitude.
    function automatic logic [MAG_W-1:0] bcd_mag(input logic [6:0] bcd);
        int tens;
        int ones;
        tens = int'(bcd[6:4]);
        ones = int'(bcd[3:0]);
        if (ones > 9) ones = 9;
        return MAG_W'(tens * 10 + ones + 1);
    endfunction

endpackage

// File: rtl/drift_level_decode.sv
module drift_level_decode
    import drift_comp_pkg::*;
(
    input  logic [CODE_W-1:0]       code_i,
    input  logic                    apply_i,
    output logic signed [SUM_W-1:0] amt_o
);

    logic [MAG_W-1:0] mag;
    int               mag_i;

    always_comb begin
        mag   = bcd_mag(code_i[6:0]);
        mag_i = int'(mag);
        if (!apply_i || code_i == 8'h01) begin
            amt_o = '0;
        end else if (code_i[7]) begin
            amt_o = SUM_W'(mag_i);
        end else begin
            amt_o = SUM_W'(-mag_i);
        end
    end

    always_comb begin
        if (!$isunknown(code_i) && !$isunknown(apply_i)) begin
            AST_AMT_RANGE: assert (int'(amt_o) <= MAG_MAX && int'(amt_o) >= -MAG_MAX); // R3
        end
    end

endmodule

// File: rtl/drift_trim_fsm.sv
module drift_trim_fsm
    import drift_comp_pkg::*;
#(
    parameter int TICK_CYCLES = 32768,
    parameter int LEN_W       = 16
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    en_i,
    input  logic                    load_i,
    input  logic signed [SUM_W-1:0] load_amt_i,
    input  logic                    sec_end_i,
    output logic [LEN_W-1:0]        next_len_o,
    output logic                    active_o
);

    localparam int HALF = TICK_CYCLES / 2;

    trim_state_t              state_q, state_d;
    logic signed [SUM_W-1:0]  budget_q, budget_d;
    int                       bud_i;
    int                       take_i;
    int                       load_i_amt;

    assign bud_i      = int'(budget_q);
    assign load_i_amt = int'(load_amt_i);
    assign take_i     = (bud_i > HALF) ? HALF : bud_i;

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q  <= ST_IDLE;
            budget_q <= '0;
        end else begin
            state_q  <= state_d;
            budget_q <= budget_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d  = state_q;
        budget_d = budget_q;
        if (!en_i) begin
            state_d  = ST_IDLE;
            budget_d = '0;
        end else if (load_i) begin
            budget_d = load_amt_i;
            if (load_i_amt > 0)      state_d = ST_ADVANCE;
            else if (load_i_amt < 0) state_d = ST_RETARD;
            else                     state_d = ST_IDLE;
        end else if (sec_end_i) begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_ADVANCE: begin
                    budget_d = SUM_W'(bud_i - take_i);
                    if (bud_i == take_i) state_d = ST_IDLE;
                end
                ST_RETARD: begin
                    budget_d = '0;
                    state_d  = ST_IDLE;
                end
                default: begin
                    state_d  = ST_IDLE;
                    budget_d = '0;
                end
            endcase
        end
    end

    // Outputs: length of the second that starts at the next tick.
    always_comb begin
        next_len_o = LEN_W'(TICK_CYCLES);
        if (en_i) begin
            unique case (state_q)
                ST_IDLE:    next_len_o = LEN_W'(TICK_CYCLES);
                ST_ADVANCE: next_len_o = LEN_W'(TICK_CYCLES - take_i);
                ST_RETARD:  next_len_o = LEN_W'(TICK_CYCLES - bud_i);
                default:    next_len_o = LEN_W'(TICK_CYCLES);
            endcase
        end
        active_o = (state_q != ST_IDLE);
    end

    AST_IDLE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_IDLE |-> budget_q == '0); // R10
    AST_ADV_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_ADVANCE |-> bud_i > 0); // R7
    AST_RET_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q == ST_RETARD |-> bud_i < 0); // R8
    AST_EN_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> state_q == ST_IDLE); // R9
    AST_RETARD_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RETARD && sec_end_i && en_i && !load_i) |=> state_q == ST_IDLE); // R8

endmodule

// File: rtl/drift_second_div.sv
module drift_second_div #(
    parameter int TICK_CYCLES = 32768,
    parameter int LEN_W       = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LEN_W-1:0] next_len_i,
    output logic             tick_o
);

    localparam int HALF = TICK_CYCLES / 2;

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cur_len_q;

    assign tick_o = (cnt_q == cur_len_q - LEN_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q     <= '0;
            cur_len_q <= LEN_W'(TICK_CYCLES);
        end else if (tick_o) begin
            cnt_q     <= '0;
            cur_len_q <= next_len_i;
        end else begin
            cnt_q     <= cnt_q + LEN_W'(1);
        end
    end

    AST_MIN_SECOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |-> int'(cnt_q) >= HALF - 1); // R7
    AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < cur_len_q); // R2

endmodule

// File: rtl/drift_compensator.sv
module drift_compensator
    import drift_comp_pkg::*;
#(
    parameter int TICK_CYCLES = 32768
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              comp_en_i,
    input  logic [CODE_W-1:0] hour_code_i,
    input  logic [CODE_W-1:0] day_code_i,
    input  logic [CODE_W-1:0] month_code_i,
    input  logic              last_min_i,
    input  logic              last_hour_i,
    input  logic              last_day_i,
    output logic              tick_o,
    output logic              trim_active_o
);

    localparam int LEN_W = $clog2(TICK_CYCLES + LEVELS * MAG_MAX + 1);

    logic [CODE_W-1:0]       codes [LEVELS];
    logic [LEVELS-1:0]       apply;
    logic signed [SUM_W-1:0] amts  [LEVELS];
    logic signed [SUM_W-1:0] total;
    logic                    min_prev_q;
    logic                    load;
    logic [LEN_W-1:0]        next_len;

    assign codes[0] = hour_code_i;
    assign codes[1] = day_code_i;
    assign codes[2] = month_code_i;
    assign apply[0] = 1'b1;
    assign apply[1] = last_hour_i;
    assign apply[2] = last_hour_i & last_day_i;

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        drift_level_decode u_dec (
            .code_i  (codes[g]),
            .apply_i (apply[g]),
            .amt_o   (amts[g])
        );
    end

    always_comb begin
        total = '0;
        for (int i = 0; i < LEVELS; i++) total = total + amts[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) min_prev_q <= 1'b0;
        else         min_prev_q <= last_min_i;
    end

    assign load = last_min_i & ~min_prev_q;

    drift_trim_fsm #(
        .TICK_CYCLES (TICK_CYCLES),
        .LEN_W       (LEN_W)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (comp_en_i),
        .load_i     (load),
        .load_amt_i (total),
        .sec_end_i  (tick_o),
        .next_len_o (next_len),
        .active_o   (trim_active_o)
    );

    drift_second_div #(
        .TICK_CYCLES (TICK_CYCLES),
        .LEN_W       (LEN_W)
    ) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .next_len_i (next_len),
        .tick_o     (tick_o)
    );

    AST_SUM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load |-> (int'(total) <= LEVELS * MAG_MAX && int'(total) >= -LEVELS * MAG_MAX)); // R6

endmodule

// File: tb/drift_compensator_tb.sv
`timescale 1ns/1ps
module drift_compensator_tb;

    localparam int NOM  = 64;
    localparam int HALF = NOM / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b1;
    logic [7:0] hcode = 8'h01, dcode = 8'h01, mcode = 8'h01;
    logic       lmin = 1'b0, lhour = 1'b0, lday = 1'b0;
    logic       tick, active;

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    int exp_len [12];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    drift_compensator #(.TICK_CYCLES(NOM)) u_dut (
        .clk_i (clk), .rst_ni (rst_n), .comp_en_i (en),
        .hour_code_i (hcode), .day_code_i (dcode), .month_code_i (mcode),
        .last_min_i (lmin), .last_hour_i (lhour), .last_day_i (lday),
        .tick_o (tick), .trim_active_o (active)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick(output int t);
        do @(negedge clk); while (!tick);
        t = cyc;
    endtask

    // Program codes, raise flags right after a tick, then measure n seconds.
    task automatic trial(input string req, input logic [7:0] h, input logic [7:0] d,
                         input logic [7:0] m, input logic lh, input logic ld,
                         input int exp_act, input int n);
        int t0, t1, t2;
        hcode = h; dcode = d; mcode = m;
        wait_tick(t0);
        @(negedge clk);
        lmin = 1'b1; lhour = lh; lday = ld;
        @(negedge clk);
        check({req, " active after load (R10)"}, int'(active), exp_act);
        wait_tick(t1);
        check({req, " running second nominal (R5)"}, t1 - t0, NOM);
        for (int k = 0; k < n; k++) begin
            wait_tick(t2);
            check(req, t2 - t1, exp_len[k]);
            t1 = t2;
        end
        check({req, " active cleared (R10)"}, int'(active), 0);
        lmin = 1'b0; lhour = 1'b0; lday = 1'b0;
    endtask

    task automatic test_reset;
        int t, c;
        repeat (3) @(negedge clk);
        check("R1 tick in reset", int'(tick), 0);
        check("R1 active in reset", int'(active), 0);
        rst_n = 1'b1;
        c = cyc;
        wait_tick(t);
        check("R1 first tick cycle", t - c, NOM - 1);
    endtask

    task automatic test_nominal;
        int t0, t1, t2;
        wait_tick(t0); wait_tick(t1); wait_tick(t2);
        check("R2 nominal period a", t1 - t0, NOM);
        check("R2 nominal period b", t2 - t1, NOM);
    endtask

    task automatic test_disable_mid;
        int t0, t1, t2, t3;
        hcode = 8'hF9; dcode = 8'hF9; mcode = 8'hF9;
        wait_tick(t0);
        @(negedge clk);
        lmin = 1'b1; lhour = 1'b1; lday = 1'b1;
        wait_tick(t1);
        wait_tick(t2);
        check("R9 first shortened second", t2 - t1, HALF);
        en = 1'b0;
        wait_tick(t3);
        check("R9 dropped budget nominal", t3 - t2, NOM);
        check("R9 active cleared", int'(active), 0);
        lmin = 1'b0; lhour = 1'b0; lday = 1'b0;
        en = 1'b1;
        wait_tick(t2);
        check("R9 stays nominal", t2 - t3, NOM);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        test_reset();
        test_nominal();
        // R3 R5: hourly add 5 (code 0x84)
        exp_len[0] = 59; exp_len[1] = 64;
        trial("R3 R5 hourly add", 8'h84, 8'h01, 8'h01, 1'b0, 1'b0, 1, 2);
        // R3 R8: hourly remove 10 (code 0x09)
        exp_len[0] = 74; exp_len[1] = 64;
        trial("R3 R8 hourly remove", 8'h09, 8'h01, 8'h01, 1'b0, 1'b0, 1, 2);
        // R4: code 0x01 is no correction
        exp_len[0] = 64; exp_len[1] = 64;
        trial("R4 no-correction code", 8'h01, 8'h01, 8'h01, 1'b1, 1'b1, 0, 2);
        // R6: +3 +4 -1 = +6
        exp_len[0] = 58; exp_len[1] = 64;
        trial("R6 nested sum", 8'h82, 8'h83, 8'h00, 1'b1, 1'b1, 1, 2);
        // R6: daily excluded outside last hour, -1 only
        exp_len[0] = 65; exp_len[1] = 64;
        trial("R6 daily excluded", 8'h00, 8'h89, 8'h89, 1'b0, 1'b1, 1, 2);
        // R3: ones digit 0xF saturates to 9 -> add 10
        exp_len[0] = 54; exp_len[1] = 64;
        trial("R3 bcd saturate", 8'h8F, 8'h01, 8'h01, 1'b0, 1'b0, 1, 2);
        // R7: 240 added, spread at most HALF per second
        for (int k = 0; k < 7; k++) exp_len[k] = HALF;
        exp_len[7] = NOM - 16; exp_len[8] = NOM;
        trial("R7 spread advance", 8'hF9, 8'hF9, 8'hF9, 1'b1, 1'b1, 1, 9);
        // R9: disabled, no load
        en = 1'b0;
        exp_len[0] = 64; exp_len[1] = 64;
        trial("R9 disabled", 8'h84, 8'h01, 8'h01, 1'b0, 1'b0, 0, 2);
        en = 1'b1;
        test_disable_mid();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule